// File: doc/BRIEF.md
# Supply-Loss Protection Sequencer

This block supervises a battery-backed byte memory from three comparator flags that arrive from the analog side without any clock relationship. The flags say whether the supply is at or above the upper deselect threshold, whether it has fallen below the lower deselect threshold, and whether it has dropped under the battery switchover level. The block synchronizes the flags and runs a four-state controller. That controller deselects and write-protects the memory on the first sign of trouble, requests high impedance on the memory's data outputs, selects the battery while the supply is under the switchover level, and holds protection for a programmable recovery time once good power has come back.

Host chip-enable and write-enable requests pass to the memory only while the controller is in normal operation. If a write is in progress at the moment protection takes hold, a sticky flag records it. Only that one location may have been corrupted, and software clears the flag with a one-cycle pulse.

The states are NORMAL, PROTECT, BATTERY and RECOVER. Reset enters PROTECT. Here is each transition:
- PROTECT goes to BATTERY when the switchover flag is set.
- PROTECT goes to RECOVER once the glitch filter has seen good power for FILT_LEN consecutive cycles.
- RECOVER goes to BATTERY on the switchover flag and to PROTECT on any out-of-tolerance flag. Either exit abandons the recovery count, which starts from zero on the next entry.
- RECOVER goes to NORMAL once it has lasted REC_CYCLES cycles.
- NORMAL goes to BATTERY or to PROTECT on the first out-of-tolerance indication.
- BATTERY goes to PROTECT when the switchover flag clears.

Top module: `pf_supervisor`

## Requirements
- R1: While reset is held and directly after it, prot_o=1, hiz_o=1, bat_sel_o=0 and wcut_o=0.
- R2: A supply fault is either sup_ok_raw=0 or sup_low_raw=1. When a fault appears between clock edges in NORMAL, prot_o and hiz_o are 1 from the 3rd following rising edge onward.
- R3: mem_ce_o=host_ce and mem_we_o=host_we in NORMAL. While prot_o=1 both outputs are 0, whatever the host drives.
- R4: When good power appears (sup_ok_raw=1, sup_low_raw=0, sup_bat_raw=0) and then stays, prot_o falls at exactly the (3+FILT_LEN+REC_CYCLES)th rising edge after the change. This holds after reset as well as after a fault.
- R5: A fault during recovery restarts the recovery. prot_o falls exactly 3+FILT_LEN+REC_CYCLES edges after the last return of good power, not earlier.
- R6: A fault on either flag that lasts only L whole cycles, for any L of 1 or more, still causes protection. Release then comes L+3+FILT_LEN+REC_CYCLES edges after the fault began.
- R7: bat_sel_o rises 3 edges after sup_bat_raw rises and falls 3 edges after it falls. prot_o stays 1 throughout, and the full recovery of R4 follows.
- R8: wcut_o is set at the edge where protection takes hold if host_ce=1 and host_we=1 in the cycle before that edge. It is not set if no write was active.
- R9: wcut_o stays set through recovery and normal operation until wcut_clr is 1 at a rising edge. It reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_ok_raw | input | 1 | Asynchronous flag: supply at or above upper deselect threshold |
| sup_low_raw | input | 1 | Asynchronous flag: supply below lower deselect threshold |
| sup_bat_raw | input | 1 | Asynchronous flag: supply below battery switchover level |
| host_ce | input | 1 | Host chip-enable request, active high |
| host_we | input | 1 | Host write-enable request, active high |
| wcut_clr | input | 1 | Clears the interrupted-write flag |
| prot_o | output | 1 | Chip deselect and write protect |
| hiz_o | output | 1 | Output high-impedance request |
| bat_sel_o | output | 1 | Select battery as memory supply |
| mem_ce_o | output | 1 | Gated chip enable to the memory |
| mem_we_o | output | 1 | Gated write enable to the memory |
| wcut_o | output | 1 | Sticky flag: write interrupted by power loss |

## Verification
Each raw flag passes through two synchronizer flops and then the state register, so protection and battery select respond exactly three edges after a flag change. Release takes a further FILT_LEN filter cycles plus REC_CYCLES recovery cycles. The gated enables are combinational from the state and follow it in the same cycle. The bench drives every stimulus on a falling edge and samples one time unit after each rising edge. In the fault sweeps it predicts prot_o and the gated enables for every single cycle from the formula for that cycle's edge count. The other checks count rising edges until an output changes and compare the count with the exact figure from the requirement.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_PROTECT = 2'd1,
        ST_BATTERY = 2'd2,
        ST_RECOVER = 2'd3
    } pf_state_t;
endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int  WIDTH   = 3,
    parameter int  STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pf_filter.sv
module pf_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_s,
    output logic good
);
    localparam int CW = $clog2(FILT_LEN + 1);
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             run_cnt <= '0;
        else if (fault_s)                       run_cnt <= '0;
        else if (run_cnt != CW'(FILT_LEN))      run_cnt <= run_cnt + 1'b1;
    end

    assign good = (run_cnt == CW'(FILT_LEN));

    AST_GOOD_AFTER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> !$past(fault_s)); // R6
endmodule

// File: rtl/pf_rec_timer.sv
module pf_rec_timer #(
    parameter int REC_CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int TW = $clog2(REC_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(REC_CYCLES - 1);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R4
    AST_RESTART_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R5
endmodule

// File: rtl/pf_supervisor.sv
module pf_supervisor
    import pf_pkg::*;
#(
    parameter int FILT_LEN   = 4,
    parameter int REC_CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok_raw,
    input  logic sup_low_raw,
    input  logic sup_bat_raw,
    input  logic host_ce,
    input  logic host_we,
    input  logic wcut_clr,
    output logic prot_o,
    output logic hiz_o,
    output logic bat_sel_o,
    output logic mem_ce_o,
    output logic mem_we_o,
    output logic wcut_o
);
    localparam logic [2:0] SYNC_RST = 3'b010; // {bat, low, ok}: low asserted, ok clear

    logic [2:0] flags_s;
    logic       ok_s, low_s, bat_s, fault_s, good, rec_done, write_act;
    pf_state_t  state, state_nx;

    pf_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(SYNC_RST)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sup_bat_raw, sup_low_raw, sup_ok_raw}),
        .dout (flags_s)
    );

    assign ok_s    = flags_s[0];
    assign low_s   = flags_s[1];
    assign bat_s   = flags_s[2];
    assign fault_s = !ok_s || low_s || bat_s;

    pf_filter #(.FILT_LEN(FILT_LEN)) i_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault_s(fault_s),
        .good   (good)
    );

    pf_rec_timer #(.REC_CYCLES(REC_CYCLES)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == ST_RECOVER),
        .done (rec_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PROTECT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL: begin
                if (bat_s)        state_nx = ST_BATTERY;
                else if (fault_s) state_nx = ST_PROTECT;
            end
            ST_PROTECT: begin
                if (bat_s)        state_nx = ST_BATTERY;
                else if (good)    state_nx = ST_RECOVER;
            end
            ST_BATTERY: begin
                if (!bat_s)       state_nx = ST_PROTECT;
            end
            ST_RECOVER: begin
                if (bat_s)        state_nx = ST_BATTERY;
                else if (fault_s) state_nx = ST_PROTECT;
                else if (rec_done) state_nx = ST_NORMAL;
            end
            default:              state_nx = ST_PROTECT;
        endcase
    end

    // outputs
    always_comb begin
        prot_o    = 1'b1;
        bat_sel_o = 1'b0;
        unique case (state)
            ST_NORMAL:  prot_o    = 1'b0;
            ST_PROTECT: prot_o    = 1'b1;
            ST_BATTERY: bat_sel_o = 1'b1;
            ST_RECOVER: prot_o    = 1'b1;
            default:    prot_o    = 1'b1;
        endcase
        hiz_o    = prot_o;
        mem_ce_o = host_ce && !prot_o;
        mem_we_o = host_we && !prot_o;
    end

    assign write_act = host_ce && host_we;

    // sticky interrupted-write flag; a new cut wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wcut_o <= 1'b0;
        else if (state == ST_NORMAL && state_nx != ST_NORMAL && write_act)
            wcut_o <= 1'b1;
        else if (wcut_clr)
            wcut_o <= 1'b0;
    end

    AST_FAULT_LEAVES_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        fault_s |=> (state != ST_NORMAL)); // R2
    AST_NO_SKIP_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROTECT) |=> (state != ST_NORMAL)); // R4
    AST_BATTERY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        bat_s |=> bat_sel_o); // R7
    AST_NO_ACCESS_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NORMAL) |-> (!mem_we_o && !mem_ce_o)); // R3
    AST_WCUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcut_o) |-> ($past(write_act) && prot_o)); // R8
    AST_WCUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wcut_o && !wcut_clr) |=> wcut_o); // R9
endmodule

// File: tb/test_pf_supervisor.sv
module test_pf_supervisor;
    localparam int F   = 4;
    localparam int REC = 40;
    localparam int REL = 3 + F + REC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ok_r = 1'b1, low_r = 1'b0, bat_r = 1'b0;
    logic hce = 1'b0, hwe = 1'b0, clr = 1'b0;
    logic prot, hiz, bsel, mce, mwe, wcut;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_f = 1'b0;

    always #10 clk = ~clk;

    pf_supervisor #(.FILT_LEN(F), .REC_CYCLES(REC)) i_pf_supervisor (
        .clk(clk), .rst_n(rst_n),
        .sup_ok_raw(ok_r), .sup_low_raw(low_r), .sup_bat_raw(bat_r),
        .host_ce(hce), .host_we(hwe), .wcut_clr(clr),
        .prot_o(prot), .hiz_o(hiz), .bat_sel_o(bsel),
        .mem_ce_o(mce), .mem_we_o(mwe), .wcut_o(wcut)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic neg();
        @(negedge clk);
    endtask

    task automatic edges_until_prot(input logic tgt, output int n);
        n = 0;
        while (prot !== tgt && n < 500) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic edges_until_bsel(input logic tgt, output int n);
        n = 0;
        while (bsel !== tgt && n < 500) begin
            @(posedge clk); #1; n++;
        end
    endtask

    initial begin
        int n;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 prot", prot, 1); chk("R1 hiz", hiz, 1);
        chk("R1 bsel", bsel, 0); chk("R1 wcut", wcut, 0);
        neg(); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 prot after release", prot, 1);
        // R4: release from reset
        edges_until_prot(1'b0, n);
        chk("R4 release after reset", n + 1, REL);

        // R3: pass-through in NORMAL
        neg(); hce = 1'b1; hwe = 1'b1; #1;
        chk("R3 mem_ce normal", mce, 1); chk("R3 mem_we normal", mwe, 1);
        neg(); hwe = 1'b0; #1;
        chk("R3 mem_we follows host", mwe, 0); chk("R3 mem_ce follows host", mce, 1);
        hwe = 1'b1;

        // R2/R3/R6/R8/R9: fault sweeps on both flags, every glitch length
        for (int kind = 0; kind < 2; kind++) begin
            for (int L = 1; L <= 6; L++) begin
                int bad;
                bad = 0;
                neg();
                if (kind == 0) ok_r = 1'b0; else low_r = 1'b1;
                for (int c = 1; c <= L + REL + 4; c++) begin
                    logic ep;
                    @(posedge clk); #1;
                    ep = (c >= 3) && (c < L + REL);
                    if (prot !== ep || hiz !== ep || mwe !== !ep || mce !== !ep) bad++;
                    @(negedge clk);
                    if (c == L) begin ok_r = 1'b1; low_r = 1'b0; end
                end
                chk($sformatf("R2 R6 R3 sweep kind%0d len%0d mismatching cycles", kind, L), bad, 0);
                chk("R8 wcut set by active write", wcut, 1);
                clr = 1'b1; @(posedge clk); #1; clr = 1'b0;
                chk("R9 wcut cleared", wcut, 0);
            end
        end

        // R8 no write active: no flag
        neg(); hce = 1'b0; hwe = 1'b0; ok_r = 1'b0;
        edges_until_prot(1'b1, n);
        chk("R2 deselect latency", n, 3);
        repeat (4) @(posedge clk); #1;
        chk("R8 no flag without write", wcut, 0);
        chk("R3 blocked while protected", mwe, 0);
        neg(); hce = 1'b1; hwe = 1'b1; #1;
        chk("R3 host ignored while protected", mce | mwe, 0);
        hce = 1'b0; hwe = 1'b0;

        // R5: fault during recovery restarts the timer
        neg(); ok_r = 1'b1;
        repeat (30) @(posedge clk); #1;
        chk("R5 still protected mid recovery", prot, 1);
        neg(); ok_r = 1'b0;
        neg(); ok_r = 1'b1;
        edges_until_prot(1'b0, n);
        chk("R5 release restarts", n, REL);

        // R9 sticky through recovery; R7 battery
        neg(); hce = 1'b1; hwe = 1'b1; ok_r = 1'b0; low_r = 1'b1;
        edges_until_prot(1'b1, n);
        neg(); hce = 1'b0; hwe = 1'b0; bat_r = 1'b1;
        edges_until_bsel(1'b1, n);
        chk("R7 battery select latency", n, 3);
        repeat (10) @(posedge clk); #1;
        chk("R7 protected on battery", prot, 1);
        neg(); bat_r = 1'b0;
        edges_until_bsel(1'b0, n);
        chk("R7 battery release latency", n, 3);
        chk("R7 still protected after battery", prot, 1);
        neg(); ok_r = 1'b1; low_r = 1'b0;
        edges_until_prot(1'b0, n);
        chk("R7 full recovery after battery", n, REL);
        chk("R9 wcut sticky through recovery", wcut, 1);
        neg(); clr = 1'b1; @(posedge clk); #1; clr = 1'b0;
        chk("R9 clear", wcut, 0);

        done_f = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #4000000;
        if (!done_f) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule